// File: doc/BRIEF.md
# Serial Audio Input Receiver

This block turns a two-channel serial audio stream into parallel left and right samples. A bit clock, a channel (frame) clock and a serial data line arrive from outside. All three are sampled in a fast system clock domain through synchronisers. A data bit is taken on every detected rising edge of the bit clock.

Most formats are right-justified with the most significant bit first. In these formats the word ends exactly where the channel clock toggles, and the payload is the last 16, 18 or 20 bits of each half frame. Any bits before that payload are padding. A fourth format is I2S-style: the word starts one bit clock after the toggle and carries up to 20 bits. Each completed word is sign-extended to 20 bits.

Static configuration inputs set four things:
- the word format;
- the number of bit clocks per frame;
- which channel clock level carries the left channel;
- a mono mode.

An illegal pairing of format and frame ratio raises an error flag and holds the sample outputs at zero. A long-window digital-zero detector runs on each channel.

Top module: `audio_serial_rx`

## Requirements
- R1: While reset is held and after its release, before any complete frame arrives, `left_out`, `right_out`, `smp_valid`, `zero_left` and `zero_right` are all zero.
- R2: With `cfg_fmt` = 00 the sample is the last 16 bits before the channel clock toggle, most significant bit first. Earlier bits in the half frame are ignored. Bits 19:16 of the output copy bit 15. Data is taken on rising bit clock edges.
- R3: `cfg_fmt` = 01 selects an 18-bit right-justified word and 10 selects a 20-bit word. Both follow the alignment and sign extension of R2.
- R4: `cfg_fmt` = 11 selects the I2S-style format. The most significant bit is the bit sampled on the second rising bit clock edge after the toggle. The word is the first 20 bits from there, and later bits are ignored.
- R5: `cfg_sync` 00 is internal sync, 01 means 32 bit clocks per frame, 10 means 48 and 11 means 64. `fmt_err` is high exactly when (`cfg_sync` = 01 and `cfg_fmt` ≠ 00) or (`cfg_sync` = 10 and `cfg_fmt` = 11). While it is high, both samples read zero and `smp_valid` stays low.
- R6: With `cfg_lr_pol` = 0, channel clock high carries the left channel. With `cfg_lr_pol` = 1, channel clock low carries it.
- R7: The pair {`cfg_mono`, `cfg_chsel`} selects the channel routing:
  - 00 gives stereo;
  - 10 drives the left word onto both outputs;
  - 11 drives the right word onto both outputs;
  - 01 gives stereo with zero detection off.
- R8: `smp_valid` is a one-cycle pulse, given once per frame after the right word completes, provided a left word was captured first. The outputs hold their values between pulses.
- R9: A channel's zero flag rises when that channel has delivered `ZERO_LIMIT` consecutive all-zero samples (default 32768). It stays high while zero samples continue.
- R10: A non-zero sample drops that channel's zero flag on the same update. Mode 01 of R7 and an active `fmt_err` hold both flags low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bck_in | input | 1 | Serial bit clock |
| lrck_in | input | 1 | Channel clock |
| sd_in | input | 1 | Serial data |
| cfg_fmt | input | 2 | Word format code |
| cfg_sync | input | 2 | Sync / bit clocks per frame code |
| cfg_lr_pol | input | 1 | Channel clock polarity |
| cfg_mono | input | 1 | Mono enable |
| cfg_chsel | input | 1 | Mono channel select, or zero-detect disable in stereo |
| left_out | output | 20 | Left sample, sign-extended |
| right_out | output | 20 | Right sample, sign-extended |
| smp_valid | output | 1 | New sample pair strobe |
| zero_left | output | 1 | Left channel digital-zero flag |
| zero_right | output | 1 | Right channel digital-zero flag |
| fmt_err | output | 1 | Illegal format / ratio combination |

## Verification
Some rules hold on every cycle, and the assertions watch those continuously:
- the sample strobe is a single-cycle pulse;
- an active format error empties the outputs and suppresses the strobe on the next cycle;
- mono output carries identical words;
- a word capture always follows a bit clock rising edge;
- a non-zero sample or disabled detection leaves the zero flag low on the next cycle.

Other behaviour only shows up across a whole frame, so only the directed scenarios can confirm it:
- right-justified alignment at 32, 48 and 64 bit clocks per frame, with padding ignored;
- the I2S one-bit delay;
- sign extension of negative short words;
- both channel clock polarities;
- the exact sample count at which a zero flag rises.

// File: rtl/asr_pkg.sv
package asr_pkg;
  localparam int SAMPLE_W = 20;

  typedef enum logic [1:0] {
    FMT_RJ16 = 2'b00,
    FMT_RJ18 = 2'b01,
    FMT_RJ20 = 2'b10,
    FMT_I2S  = 2'b11
  } fmt_e;

  typedef enum logic [1:0] {
    SYN_INT = 2'b00,
    SYN_32  = 2'b01,
    SYN_48  = 2'b10,
    SYN_64  = 2'b11
  } sync_e;

  // Word length carried by a format code (I2S-style uses the full width).
  function automatic int word_bits(input logic [1:0] fmt);
    case (fmt)
      2'b00:   return 16;
      2'b01:   return 18;
      default: return SAMPLE_W;
    endcase
  endfunction

  // Pairs of frame ratio and format that cannot carry the word.
  function automatic logic fmt_illegal(input logic [1:0] fmt, input logic [1:0] sync);
    return ((sync == SYN_32) && (fmt != FMT_RJ16)) ||
           ((sync == SYN_48) && (fmt == FMT_I2S));
  endfunction

  // Sign-extend the low word_bits(fmt) bits of raw to the full width.
  function automatic logic [SAMPLE_W-1:0] sext_word(input logic [SAMPLE_W-1:0] raw,
                                                     input logic [1:0] fmt);
    int sh;
    logic signed [SAMPLE_W-1:0] t;
    sh = SAMPLE_W - word_bits(fmt);
    t  = signed'(raw << sh);
    return SAMPLE_W'(t >>> sh);
  endfunction
endpackage

// File: rtl/asr_sync.sv
module asr_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/asr_deser.sv
module asr_deser
  import asr_pkg::*;
#(
  parameter int W             = SAMPLE_W,
  parameter int MAX_FRAME_BCK = 128
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bck_s,
  input  logic         lrck_s,
  input  logic         sd_s,
  input  logic [1:0]   fmt_i,
  output logic         word_stb_o,
  output logic         word_ch_o,
  output logic [W-1:0] word_raw_o
);
  localparam int HALF_MAX = MAX_FRAME_BCK / 2;
  localparam int IDX_W    = $clog2(HALF_MAX + 1);
  localparam logic [IDX_W-1:0] IDX_SAT = IDX_W'(HALF_MAX);
  localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(W);

  logic             bck_q;
  logic             lr_q;
  logic             have_lr_q;
  logic             primed_q;
  logic [W-1:0]     rj_sh_q;
  logic [W-1:0]     i2s_sh_q;
  logic [IDX_W-1:0] bit_idx_q;

  // Named internal events
  logic bck_rise;
  logic lr_edge;
  logic i2s_take;

  assign bck_rise = bck_s & ~bck_q;
  assign lr_edge  = bck_rise & have_lr_q & (lrck_s != lr_q);
  assign i2s_take = (bit_idx_q != '0) && (bit_idx_q <= IDX_TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bck_q      <= 1'b0;
      lr_q       <= 1'b0;
      have_lr_q  <= 1'b0;
      primed_q   <= 1'b0;
      rj_sh_q    <= '0;
      i2s_sh_q   <= '0;
      bit_idx_q  <= '0;
      word_stb_o <= 1'b0;
      word_ch_o  <= 1'b0;
      word_raw_o <= '0;
    end else begin
      bck_q      <= bck_s;
      word_stb_o <= 1'b0;
      if (bck_rise) begin
        lr_q      <= lrck_s;
        have_lr_q <= 1'b1;
        if (lr_edge) begin
          word_stb_o <= primed_q;
          word_ch_o  <= lr_q;
          word_raw_o <= (fmt_i == FMT_I2S) ? i2s_sh_q : rj_sh_q;
          primed_q   <= 1'b1;
          rj_sh_q    <= {{(W-1){1'b0}}, sd_s};
          i2s_sh_q   <= '0;
          bit_idx_q  <= IDX_W'(1);
        end else begin
          rj_sh_q <= {rj_sh_q[W-2:0], sd_s};
          if (i2s_take) i2s_sh_q <= {i2s_sh_q[W-2:0], sd_s};
          if (bit_idx_q != IDX_SAT) bit_idx_q <= bit_idx_q + 1'b1;
        end
      end
    end
  end

  // R2
  word_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_stb_o |-> $past(bck_rise));

  // R2
  rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bck_rise |=> !bck_rise);
endmodule

// File: rtl/asr_zero.sv
module asr_zero #(
  parameter int LIMIT = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic stb_i,
  input  logic is_zero_i,
  output logic flag_o
);
  localparam int CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] LIM = CNT_W'(LIMIT);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nx;

  assign cnt_nx = (cnt_q == LIM) ? cnt_q : cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_o <= 1'b0;
    end else if (!en_i) begin
      cnt_q  <= '0;
      flag_o <= 1'b0;
    end else if (stb_i) begin
      if (is_zero_i) begin
        cnt_q  <= cnt_nx;
        flag_o <= (cnt_nx == LIM);
      end else begin
        cnt_q  <= '0;
        flag_o <= 1'b0;
      end
    end
  end

  // R10
  nonzero_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && stb_i && !is_zero_i) |=> !flag_o);

  // R10
  disabled_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !flag_o);

  // R9
  rise_on_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_o) |-> $past(stb_i && is_zero_i));
endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx
  import asr_pkg::*;
#(
  parameter int ZERO_LIMIT    = 32768,
  parameter int SYNC_STAGES   = 2,
  parameter int MAX_FRAME_BCK = 128
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bck_in,
  input  logic                lrck_in,
  input  logic                sd_in,
  input  logic [1:0]          cfg_fmt,
  input  logic [1:0]          cfg_sync,
  input  logic                cfg_lr_pol,
  input  logic                cfg_mono,
  input  logic                cfg_chsel,
  output logic [SAMPLE_W-1:0] left_out,
  output logic [SAMPLE_W-1:0] right_out,
  output logic                smp_valid,
  output logic                zero_left,
  output logic                zero_right,
  output logic                fmt_err
);
  localparam int NCH = 2;

  logic [2:0]          sync_q;
  logic                word_stb;
  logic                word_ch;
  logic [SAMPLE_W-1:0] word_raw;

  asr_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({bck_in, lrck_in, sd_in}),
    .q_o   (sync_q)
  );

  asr_deser #(.W(SAMPLE_W), .MAX_FRAME_BCK(MAX_FRAME_BCK)) u_deser (
    .clk        (clk),
    .rst_n      (rst_n),
    .bck_s      (sync_q[2]),
    .lrck_s     (sync_q[1]),
    .sd_s       (sync_q[0]),
    .fmt_i      (cfg_fmt),
    .word_stb_o (word_stb),
    .word_ch_o  (word_ch),
    .word_raw_o (word_raw)
  );

  // Named events for the checks
  logic                cap_ok;
  logic                cap_left;
  logic [SAMPLE_W-1:0] cap_val;
  logic                zd_en;

  assign fmt_err  = fmt_illegal(cfg_fmt, cfg_sync);
  assign cap_ok   = word_stb & ~fmt_err;
  assign cap_left = (word_ch == ~cfg_lr_pol);
  assign cap_val  = sext_word(word_raw, cfg_fmt);
  assign zd_en    = ~fmt_err & ~(~cfg_mono & cfg_chsel);

  logic [SAMPLE_W-1:0] left_hold_q;
  logic                have_left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_hold_q <= '0;
      have_left_q <= 1'b0;
      left_out    <= '0;
      right_out   <= '0;
      smp_valid   <= 1'b0;
    end else if (fmt_err) begin
      left_hold_q <= '0;
      have_left_q <= 1'b0;
      left_out    <= '0;
      right_out   <= '0;
      smp_valid   <= 1'b0;
    end else begin
      smp_valid <= 1'b0;
      if (cap_ok) begin
        if (cap_left) begin
          left_hold_q <= cap_val;
          have_left_q <= 1'b1;
        end else if (have_left_q) begin
          have_left_q <= 1'b0;
          smp_valid   <= 1'b1;
          if (cfg_mono && !cfg_chsel) begin
            left_out  <= left_hold_q;
            right_out <= left_hold_q;
          end else if (cfg_mono) begin
            left_out  <= cap_val;
            right_out <= cap_val;
          end else begin
            left_out  <= left_hold_q;
            right_out <= cap_val;
          end
        end
      end
    end
  end

  logic [NCH-1:0] zflag;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_zero
    logic ch_stb;
    assign ch_stb = cap_ok & (cap_left == (ch == 0));
    asr_zero #(.LIMIT(ZERO_LIMIT)) u_zero (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_i      (zd_en),
      .stb_i     (ch_stb),
      .is_zero_i (cap_val == '0),
      .flag_o    (zflag[ch])
    );
  end

  assign zero_left  = zflag[0];
  assign zero_right = zflag[1];

  // R5
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_err |=> (left_out == '0 && right_out == '0 && !smp_valid));

  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> !smp_valid);

  // R7
  mono_dup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && $past(cfg_mono)) |-> (left_out == right_out));

  // R8
  valid_after_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> $past(word_stb));
endmodule

// File: tb/test_audio_serial_rx.sv
module test_audio_serial_rx;
  localparam real CLK_NS = 4.0;
  localparam int  ZL     = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bck = 1'b1, lrck = 1'b0, sd = 1'b0;
  logic [1:0]  fmt = 2'b00, syn = 2'b11;
  logic        pol = 1'b0, mono = 1'b0, chsel = 1'b0;
  logic [19:0] lo, ro;
  logic        vld, zl, zr, ferr;

  int errors = 0;
  int checks = 0;
  int vcount = 0;

  always #(CLK_NS/2) clk = ~clk;

  audio_serial_rx #(.ZERO_LIMIT(ZL)) i_audio_serial_rx (
    .clk(clk), .rst_n(rst_n), .bck_in(bck), .lrck_in(lrck), .sd_in(sd),
    .cfg_fmt(fmt), .cfg_sync(syn), .cfg_lr_pol(pol), .cfg_mono(mono),
    .cfg_chsel(chsel), .left_out(lo), .right_out(ro), .smp_valid(vld),
    .zero_left(zl), .zero_right(zr), .fmt_err(ferr)
  );

  always @(posedge clk) if (rst_n && vld) vcount++;

  task automatic check(input string tag, input logic [19:0] act, input logic [19:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [19:0] ext(input logic [19:0] v, input int n);
    logic [19:0] r;
    r = v;
    for (int b = n; b < 20; b++) r[b] = v[n-1];
    return r;
  endfunction

  function automatic logic bit_for(input int i, input int h, input logic [19:0] d);
    int n;
    if (fmt == 2'b11) begin
      if (i >= 1 && i <= 20) return d[20-i];
      return 1'b1;
    end
    n = (fmt == 2'b00) ? 16 : (fmt == 2'b01) ? 18 : 20;
    if (i < h - n) return 1'b1;
    return d[n-1-(i-(h-n))];
  endfunction

  function automatic logic left_lvl();
    return ~pol;
  endfunction

  task automatic do_reset(input logic [1:0] f, input logic [1:0] s, input logic p,
                          input logic m, input logic c);
    @(negedge clk);
    rst_n = 1'b0;
    fmt = f; syn = s; pol = p; mono = m; chsel = c;
    bck = 1'b1; sd = 1'b0; lrck = ~left_lvl();
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    vcount = 0;
  endtask

  task automatic send_half(input logic lvl, input logic [19:0] d, input int h);
    for (int i = 0; i < h; i++) begin
      @(negedge clk);
      bck = 1'b0; lrck = lvl; sd = bit_for(i, h, d);
      @(negedge clk);
      @(negedge clk);
      bck = 1'b1;
      @(negedge clk);
    end
  endtask

  task automatic send_frame(input logic [19:0] l, input logic [19:0] r, input int h);
    send_half(left_lvl(), l, h);
    send_half(~left_lvl(), r, h);
  endtask

  task automatic close_frame(input int h);
    send_half(left_lvl(), 20'h0, h);
    repeat (20) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 left in reset", lo, 20'h0);
    check("R1 valid in reset", {19'h0, vld}, 20'h0);
    do_reset(2'b00, 2'b11, 1'b0, 1'b0, 1'b0);
    check("R1 right after reset", ro, 20'h0);
    check("R1 zero flags after reset", {18'h0, zl, zr}, 20'h0);
  endtask

  task automatic t_rj16();
    do_reset(2'b00, 2'b01, 1'b0, 1'b0, 1'b0);
    check("R5 legal 16b@32", {19'h0, ferr}, 20'h0);
    send_frame(20'h0AAAA, 20'h05555, 16);
    send_frame(20'h08001, 20'h01234, 16);
    close_frame(16);
    check("R2 left 16b sign ext", lo, ext(20'h08001, 16));
    check("R2 right 16b", ro, 20'h01234);
    check("R8 two strobes for two frames", 20'(vcount), 20'd2);
    do_reset(2'b00, 2'b11, 1'b0, 1'b0, 1'b0);
    send_frame(20'h0FFFE, 20'h07FFF, 32);
    close_frame(32);
    check("R2 padding ignored left", lo, ext(20'h0FFFE, 16));
    check("R2 padding ignored right", ro, 20'h07FFF);
  endtask

  task automatic t_rj18();
    do_reset(2'b01, 2'b10, 1'b0, 1'b0, 1'b0);
    send_frame(20'h20005, 20'h1FFFF, 24);
    close_frame(24);
    check("R3 left 18b negative", lo, ext(20'h20005, 18));
    check("R3 right 18b positive", ro, 20'h1FFFF);
  endtask

  task automatic t_rj20_pol();
    do_reset(2'b10, 2'b11, 1'b1, 1'b0, 1'b0);
    send_frame(20'h80000, 20'h7FFFF, 32);
    close_frame(32);
    check("R3 R6 left 20b low-level", lo, 20'h80000);
    check("R3 R6 right 20b", ro, 20'h7FFFF);
    do_reset(2'b00, 2'b11, 1'b1, 1'b0, 1'b0);
    send_frame(20'h00011, 20'h00022, 32);
    close_frame(32);
    check("R6 left on low level", lo, 20'h00011);
    check("R6 right on high level", ro, 20'h00022);
  endtask

  task automatic t_i2s();
    do_reset(2'b11, 2'b11, 1'b1, 1'b0, 1'b0);
    check("R5 i2s legal at 64", {19'h0, ferr}, 20'h0);
    send_frame(20'hABCDE, 20'h12345, 32);
    close_frame(32);
    check("R4 i2s left", lo, 20'hABCDE);
    check("R4 i2s right", ro, 20'h12345);
  endtask

  task automatic t_mono();
    do_reset(2'b00, 2'b11, 1'b0, 1'b1, 1'b0);
    send_frame(20'h00100, 20'h00200, 32);
    close_frame(32);
    check("R7 mono left on L", lo, 20'h00100);
    check("R7 mono left on R", ro, 20'h00100);
    do_reset(2'b00, 2'b11, 1'b0, 1'b1, 1'b1);
    send_frame(20'h00100, 20'h00200, 32);
    close_frame(32);
    check("R7 mono right on L", lo, 20'h00200);
    check("R7 mono right on R", ro, 20'h00200);
  endtask

  task automatic t_illegal();
    do_reset(2'b10, 2'b01, 1'b0, 1'b0, 1'b0);
    check("R5 20b at 32 flagged", {19'h0, ferr}, 20'h1);
    send_frame(20'h12345, 20'h54321, 32);
    close_frame(32);
    check("R5 left held zero", lo, 20'h0);
    check("R5 right held zero", ro, 20'h0);
    check("R5 no strobe", 20'(vcount), 20'd0);
    do_reset(2'b11, 2'b10, 1'b0, 1'b0, 1'b0);
    check("R5 i2s at 48 flagged", {19'h0, ferr}, 20'h1);
    do_reset(2'b11, 2'b00, 1'b0, 1'b0, 1'b0);
    check("R5 i2s internal sync legal", {19'h0, ferr}, 20'h0);
  endtask

  task automatic t_zero();
    do_reset(2'b00, 2'b11, 1'b0, 1'b0, 1'b0);
    for (int k = 0; k < ZL - 1; k++) send_frame(20'h0, 20'h0, 32);
    close_frame(32);
    check("R9 flags low one short of limit", {18'h0, zl, zr}, 20'h0);
    send_frame(20'h0, 20'h0, 32);
    close_frame(32);
    check("R9 flags high at limit", {18'h0, zl, zr}, 20'h3);
    send_frame(20'h00005, 20'h0, 32);
    close_frame(32);
    check("R10 left cleared by non-zero", {19'h0, zl}, 20'h0);
    check("R9 right stays high", {19'h0, zr}, 20'h1);
  endtask

  task automatic t_zero_off();
    do_reset(2'b00, 2'b11, 1'b0, 1'b0, 1'b1);
    for (int k = 0; k < ZL + 2; k++) send_frame(20'h0, 20'h0, 32);
    close_frame(32);
    check("R10 detection disabled", {18'h0, zl, zr}, 20'h0);
    send_frame(20'h00003, 20'h00007, 32);
    close_frame(32);
    check("R7 mode 01 stays stereo left", lo, 20'h00003);
    check("R7 mode 01 stays stereo right", ro, 20'h00007);
  endtask

  initial begin
    t_reset();
    t_rj16();
    t_rj18();
    t_rj20_pol();
    t_i2s();
    t_mono();
    t_illegal();
    t_zero();
    t_zero_off();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(150000 * CLK_NS);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule